// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Increment

This block lets a two-wire serial bus master configure a bank of 26 byte-wide control registers. Both bus lines are sampled by the system clock. The block finds start and stop conditions and answers its 7-bit device address, one bit of which follows an external select pin. It acknowledges on the ninth clock. In a write transfer, the second byte sets the register pointer and each later byte is stored at the pointer, which then steps by one. A read transfer returns bytes from the current pointer, which also steps by one, until the master declines a byte.

Four consecutive registers together hold a 32-bit frequency word. The word seen at the output changes only when the most significant of the four bytes is written, so a master that writes the bytes in ascending order never exposes a half-updated value. Reset loads fixed defaults: two mode registers are non-zero, the four frequency bytes hold 21F07C16h, and every other register is cleared.

The protocol engine is a state machine with these states: LK_IDLE, LK_ADDR, LK_ADDR_ACK, LK_SUB, LK_SUB_ACK, LK_WDATA, LK_WDATA_ACK, LK_RDATA, LK_RDATA_ACK. Its transitions are as follows:
- A stop takes any state to LK_IDLE.
- A start takes any state to LK_ADDR.
- After eight bits, LK_ADDR goes to LK_ADDR_ACK on a match and to LK_IDLE on a miss.
- LK_ADDR_ACK goes to LK_RDATA for a read and to LK_SUB for a write.
- LK_SUB goes to LK_SUB_ACK, then LK_WDATA.
- LK_WDATA and LK_WDATA_ACK alternate.
- LK_RDATA goes to LK_RDATA_ACK. From LK_RDATA_ACK, a master acknowledge returns to LK_RDATA and a refusal goes to LK_IDLE.

Every move other than start and stop happens on a falling SCL edge.

Top module: `ctl_serial_regbank`

## Requirements
- R1: After reset, register 1 reads 48h (bits 3 and 6 set) and register 4 reads 10h (bit 4 set). Registers 5, 6, 7 and 8 hold 16h, 7Ch, F0h and 21h. All other registers are 00h, and the frequency word output is 21F07C16h.
- R2: The device address is binary 0 1 0 1 0 S 0, where S is the level of `addr_sel` (28h or 2Ah). The first byte is sent MSB first with R/W as its LSB (0 = write, 1 = read). A matching first byte is acknowledged by holding SDA low through the ninth SCL high phase.
- R3: A first byte with any other address gets no acknowledge. Bytes that follow it, up to the next start, get no acknowledge and change no register.
- R4: In a write transfer, the second byte loads the pointer. Each further byte is acknowledged, stored in the register the pointer selects, and then the pointer increments.
- R5: In a read transfer, the slave sends the register at the pointer MSB first and then increments the pointer. A master acknowledge (SDA low on the ninth clock) continues with the next register. A master refusal ends the transfer and leaves SDA released.
- R6: A pointer value of 26 or more selects no register. Writes there change nothing, and reads there return 00h.
- R7: The frequency word output is {reg8, reg7, reg6, reg5}. It changes only in the cycle after register 8 is written, and it then takes the new byte together with the current registers 5 to 7.
- R8: A repeated start restarts the address phase and keeps the pointer, so a write of the pointer followed by a repeated start and a read address reads from that pointer. A stop releases SDA.
- R9: The slave changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, loads register defaults |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Sets the selectable device address bit |
| regs_flat | output | NUM_REGS*8 | All registers, register n at bits n*8+7..n*8 |
| freq_word | output | 32 | Committed frequency word |

## Verification
Storing the top frequency byte and committing the whole 32-bit word happen in the same clock cycle, and both are driven by one write strobe. The bench provokes this with an ascending burst through all registers. It checks the word after each of the bytes for registers 7 and 8: the word must still hold its old value after register 7 and must equal the four new bytes after register 8. Single-byte writes to register 5 and then register 8 confirm that the commit takes the current lower bytes rather than a copy from the start of the transfer. The same burst runs the pointer past the last register in the middle of the transfer, so a store that is dropped and a pointer that keeps incrementing fall together there; the bench judges this by reading back all registers and the 00h returns.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    typedef enum logic [3:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_SUB,
        LK_SUB_ACK,
        LK_WDATA,
        LK_WDATA_ACK,
        LK_RDATA,
        LK_RDATA_ACK
    } link_state_t;

    localparam int          MODE_A_IDX_D  = 1;
    localparam int          MODE_B_IDX_D  = 4;
    localparam int          FREQ_IDX_D    = 5;
    localparam logic [7:0]  MODE_A_INIT_D = 8'h48;
    localparam logic [7:0]  MODE_B_INIT_D = 8'h10;
    localparam logic [31:0] FREQ_INIT_D   = 32'h21F07C16;

    // Reset value for register idx, given where the non-zero registers sit.
    function automatic logic [7:0] reg_init(
        input int          idx,
        input int          ma_idx,
        input int          mb_idx,
        input int          fq_idx,
        input logic [7:0]  ma_val,
        input logic [7:0]  mb_val,
        input logic [31:0] fq_val
    );
        logic [31:0] shifted;
        if (idx == ma_idx) return ma_val;
        if (idx == mb_idx) return mb_val;
        if (idx >= fq_idx && idx < fq_idx + 4) begin
            shifted = fq_val >> ((idx - fq_idx) * 8);
            return shifted[7:0];
        end
        return 8'h00;
    endfunction

endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // Idle bus level is high; reset the pipes high to avoid phantom edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/ctl_link_fsm.sv
module ctl_link_fsm
    import ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         SEL_BIT  = 1,
    parameter int         PTR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             addr_sel,
    input  logic [7:0]       rd_byte,
    output logic [PTR_W-1:0] rd_addr,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data
);

    localparam logic [3:0] BYTE_BITS = 4'd8;

    link_state_t      state, state_nx;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [PTR_W-1:0] ptr;
    logic             rw_q;
    logic             mst_ack;
    logic [6:0]       my_addr;
    logic             addr_hit;
    logic             byte_done;

    always_comb begin
        my_addr          = DEV_ADDR;
        my_addr[SEL_BIT] = addr_sel;
    end

    assign addr_hit  = (rx_sh[7:1] == my_addr);
    assign byte_done = scl_fall && (bit_cnt == BYTE_BITS);
    assign rd_addr   = ptr;

    // Next-state logic.
    always_comb begin
        state_nx = state;
        if (bus_stop) begin
            state_nx = LK_IDLE;
        end else if (bus_start) begin
            state_nx = LK_ADDR;
        end else begin
            unique case (state)
                LK_IDLE:      state_nx = LK_IDLE;
                LK_ADDR:      if (byte_done) state_nx = addr_hit ? LK_ADDR_ACK : LK_IDLE;
                LK_ADDR_ACK:  if (scl_fall)  state_nx = rw_q ? LK_RDATA : LK_SUB;
                LK_SUB:       if (byte_done) state_nx = LK_SUB_ACK;
                LK_SUB_ACK:   if (scl_fall)  state_nx = LK_WDATA;
                LK_WDATA:     if (byte_done) state_nx = LK_WDATA_ACK;
                LK_WDATA_ACK: if (scl_fall)  state_nx = LK_WDATA;
                LK_RDATA:     if (byte_done) state_nx = LK_RDATA_ACK;
                LK_RDATA_ACK: if (scl_fall)  state_nx = mst_ack ? LK_RDATA : LK_IDLE;
                default:      state_nx = LK_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_IDLE;
        else        state <= state_nx;
    end

    // Outputs and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            rw_q     <= 1'b0;
            mst_ack  <= 1'b0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bus_stop || bus_start) begin
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
            end else begin
                unique case (state)
                    LK_ADDR, LK_SUB, LK_WDATA: begin
                        if (scl_rise && bit_cnt < BYTE_BITS) begin
                            rx_sh   <= {rx_sh[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == LK_ADDR) begin
                                if (addr_hit) begin
                                    rw_q     <= rx_sh[0];
                                    sda_pull <= 1'b1;
                                end
                            end else if (state == LK_SUB) begin
                                ptr      <= rx_sh;
                                sda_pull <= 1'b1;
                            end else begin
                                wr_en    <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= rx_sh;
                                ptr      <= ptr + 1'b1;
                                sda_pull <= 1'b1;
                            end
                        end
                    end
                    LK_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                tx_sh    <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                                ptr      <= ptr + 1'b1;
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    LK_SUB_ACK, LK_WDATA_ACK: begin
                        if (scl_fall) sda_pull <= 1'b0;
                    end
                    LK_RDATA: begin
                        if (scl_rise && bit_cnt < BYTE_BITS) bit_cnt <= bit_cnt + 4'd1;
                        if (scl_fall) begin
                            if (bit_cnt == BYTE_BITS) begin
                                sda_pull <= 1'b0;
                                bit_cnt  <= '0;
                            end else begin
                                tx_sh    <= {tx_sh[6:0], 1'b0};
                                sda_pull <= ~tx_sh[6];
                            end
                        end
                    end
                    LK_RDATA_ACK: begin
                        if (scl_rise) mst_ack <= ~sda_lvl;
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (mst_ack) begin
                                tx_sh    <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                                ptr      <= ptr + 1'b1;
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    default: sda_pull <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
    import ctl_pkg::*;
#(
    parameter int          NUM_REGS    = 26,
    parameter int          PTR_W       = 8,
    parameter int          MODE_A_IDX  = MODE_A_IDX_D,
    parameter int          MODE_B_IDX  = MODE_B_IDX_D,
    parameter int          FREQ_IDX    = FREQ_IDX_D,
    parameter logic [7:0]  MODE_A_INIT = MODE_A_INIT_D,
    parameter logic [7:0]  MODE_B_INIT = MODE_B_INIT_D,
    parameter logic [31:0] FREQ_INIT   = FREQ_INIT_D
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic [31:0]           freq_word
);

    localparam int               IDX_W   = $clog2(NUM_REGS);
    localparam logic [PTR_W-1:0] REG_LIM = PTR_W'(NUM_REGS);
    localparam logic [PTR_W-1:0] FREQ_HI = PTR_W'(FREQ_IDX + 3);

    logic [7:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] INIT = reg_init(g, MODE_A_IDX, MODE_B_IDX, FREQ_IDX,
                                               MODE_A_INIT, MODE_B_INIT, FREQ_INIT);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     regs_q[g] <= INIT;
            else if (wr_en && wr_addr == PTR_W'(g))         regs_q[g] <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = regs_q[g];
    end

    // Whole-word commit on the top byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            freq_word <= FREQ_INIT;
        else if (wr_en && wr_addr == FREQ_HI)
            freq_word <= {wr_data, regs_q[FREQ_IDX+2], regs_q[FREQ_IDX+1], regs_q[FREQ_IDX]};
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr < REG_LIM) rd_data = regs_q[rd_addr[IDX_W-1:0]];
    end

endmodule

// File: rtl/ctl_serial_regbank.sv
module ctl_serial_regbank
    import ctl_pkg::*;
#(
    parameter int          NUM_REGS    = 26,
    parameter logic [6:0]  DEV_ADDR    = 7'h2A,
    parameter int          SEL_BIT     = 1,
    parameter int          SYNC_STAGES = 2,
    parameter int          PTR_W       = 8,
    parameter int          MODE_A_IDX  = MODE_A_IDX_D,
    parameter int          MODE_B_IDX  = MODE_B_IDX_D,
    parameter int          FREQ_IDX    = FREQ_IDX_D,
    parameter logic [7:0]  MODE_A_INIT = MODE_A_INIT_D,
    parameter logic [7:0]  MODE_B_INIT = MODE_B_INIT_D,
    parameter logic [31:0] FREQ_INIT   = FREQ_INIT_D
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull,
    input  logic                  addr_sel,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic [31:0]           freq_word
);

    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0]       rd_byte;
    logic [PTR_W-1:0] rd_addr;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;

    ctl_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    ctl_link_fsm #(
        .DEV_ADDR(DEV_ADDR),
        .SEL_BIT (SEL_BIT),
        .PTR_W   (PTR_W)
    ) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .addr_sel (addr_sel),
        .rd_byte  (rd_byte),
        .rd_addr  (rd_addr),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    ctl_reg_file #(
        .NUM_REGS   (NUM_REGS),
        .PTR_W      (PTR_W),
        .MODE_A_IDX (MODE_A_IDX),
        .MODE_B_IDX (MODE_B_IDX),
        .FREQ_IDX   (FREQ_IDX),
        .MODE_A_INIT(MODE_A_INIT),
        .MODE_B_INIT(MODE_B_INIT),
        .FREQ_INIT  (FREQ_INIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_byte),
        .regs_flat(regs_flat),
        .freq_word(freq_word)
    );

endmodule

// File: rtl/ctl_serial_regbank_chk.sv
module ctl_serial_regbank_chk #(
    parameter int NUM_REGS = 26,
    parameter int PTR_W    = 8,
    parameter int FREQ_IDX = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_lvl,
    input logic                  bus_stop,
    input logic                  sda_pull,
    input logic                  wr_en,
    input logic [PTR_W-1:0]      wr_addr,
    input logic [7:0]            wr_data,
    input logic [NUM_REGS*8-1:0] regs_flat,
    input logic [31:0]           freq_word
);

    localparam logic [PTR_W-1:0] REG_LIM = PTR_W'(NUM_REGS);
    localparam logic [PTR_W-1:0] FREQ_HI = PTR_W'(FREQ_IDX + 3);

    logic [PTR_W-1:0] last_addr;
    logic [7:0]       byte_at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_addr <= '0;
        else        last_addr <= wr_addr;
    end

    always_comb begin
        byte_at_last = 8'h00;
        if (last_addr < REG_LIM) byte_at_last = regs_flat[int'(last_addr)*8 +: 8];
    end

    assert_pull_only_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));

    assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_pull);

    assert_freq_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == FREQ_HI) |=> $stable(freq_word));

    assert_oor_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= REG_LIM) |=> $stable(regs_flat));

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < REG_LIM) |=> (byte_at_last == $past(wr_data)));

endmodule

bind ctl_serial_regbank ctl_serial_regbank_chk #(
    .NUM_REGS(NUM_REGS),
    .PTR_W   (PTR_W),
    .FREQ_IDX(FREQ_IDX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .bus_stop (bus_stop),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .regs_flat(regs_flat),
    .freq_word(freq_word)
);

// File: tb/sim_ctl_serial_regbank.sv
`timescale 1ns/1ps
module sim_ctl_serial_regbank;

    localparam int N = 26;
    localparam int Q = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_pull = 1'b0;
    logic          addr_sel = 1'b1;
    logic          dut_pull;
    logic          sda_bus;
    logic [N*8-1:0] regs_flat;
    logic [31:0]   freq_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign sda_bus = ~(m_pull | dut_pull);

    ctl_serial_regbank u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_bus),
        .sda_pull (dut_pull),
        .addr_sel (addr_sel),
        .regs_flat(regs_flat),
        .freq_word(freq_word)
    );

    function automatic logic [7:0] dflt(int i);
        case (i)
            1: return 8'h48;
            4: return 8'h10;
            5: return 8'h16;
            6: return 8'h7C;
            7: return 8'hF0;
            8: return 8'h21;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_pull = 1'b0; q();
        m_scl  = 1'b1; q();
        m_pull = 1'b1; q();
        m_scl  = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_pull = 1'b1; q();
        m_scl  = 1'b1; q();
        m_pull = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_pull = ~b[i]; q();
            m_scl = 1'b1; q(); q();
            m_scl = 1'b0; q();
        end
        m_pull = 1'b0; q();
        m_scl = 1'b1; q();
        ack = ~sda_bus; q();
        m_scl = 1'b0; q();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        m_pull = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            q();
            m_scl = 1'b1; q();
            b[i] = sda_bus; q();
            m_scl = 1'b0;
        end
        m_pull = give_ack; q();
        m_scl = 1'b1; q(); q();
        m_scl = 1'b0; q();
        m_pull = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        bit         ack;
        logic [7:0] rb;
        logic [N*8-1:0] snap;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset defaults
        for (int i = 0; i < N; i++) chk($sformatf("R1 reg%0d", i), 32'(regs_flat[i*8 +: 8]), 32'(dflt(i)));
        chk("R1 freq word", freq_word, 32'h21F07C16);

        // R2/R3: sweep all addresses with select high
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            chk($sformatf("R2 R3 addr %02h ack", a), 32'(ack), 32'(a == 'h2A));
            if (a != 'h2A && (a % 16) == 3) begin
                send_byte(8'h00, ack);
                chk("R3 ignored sub byte ack", 32'(ack), 0);
                send_byte(8'hEE, ack);
                chk("R3 ignored data byte ack", 32'(ack), 0);
            end
            bus_stop();
        end
        chk("R3 reg0 unchanged", 32'(regs_flat[7:0]), 0);

        // R2: select low moves the address
        addr_sel = 1'b0; q();
        bus_start(); send_byte(8'h50, ack); bus_stop();
        chk("R2 sel0 addr 28h ack", 32'(ack), 1);
        bus_start(); send_byte(8'h54, ack); bus_stop();
        chk("R2 sel0 addr 2Ah nack", 32'(ack), 0);
        addr_sel = 1'b1; q();

        // R4/R6/R7: burst across all registers and past the end
        bus_start();
        send_byte(8'h54, ack);
        send_byte(8'h00, ack);
        chk("R4 sub ack", 32'(ack), 1);
        for (int i = 0; i < N + 2; i++) begin
            send_byte(pat(i), ack);
            chk($sformatf("R4 data ack %0d", i), 32'(ack), 1);
            if (i == 7) chk("R7 freq held after reg7", freq_word, 32'h21F07C16);
            if (i == 8) chk("R7 freq commit after reg8", freq_word,
                            {pat(8), pat(7), pat(6), pat(5)});
        end
        bus_stop();
        for (int i = 0; i < N; i++) chk($sformatf("R4 R6 reg%0d", i), 32'(regs_flat[i*8 +: 8]), 32'(pat(i)));

        // R5/R6/R8: pointer write, repeated start, read everything and beyond
        bus_start();
        send_byte(8'h54, ack);
        send_byte(8'h00, ack);
        bus_start();
        send_byte(8'h55, ack);
        chk("R8 read addr ack after repeated start", 32'(ack), 1);
        for (int i = 0; i < N + 2; i++) begin
            recv_byte(rb, i != N + 1);
            chk($sformatf("R5 R6 read %0d", i), 32'(rb), (i < N) ? 32'(pat(i)) : 0);
        end
        q();
        chk("R5 sda released after nack", 32'(sda_bus), 1);
        bus_stop();
        chk("R8 sda released after stop", 32'(sda_bus), 1);

        // R5: read from the middle, pointer retained, NACK ends
        bus_start();
        send_byte(8'h54, ack);
        send_byte(8'd20, ack);
        bus_start();
        send_byte(8'h55, ack);
        for (int i = 20; i < 23; i++) begin
            recv_byte(rb, i != 22);
            chk($sformatf("R5 mid read %0d", i), 32'(rb), 32'(pat(i)));
        end
        bus_stop();

        // R7: single write to reg5 does not commit; reg8 commits current bytes
        bus_start(); send_byte(8'h54, ack); send_byte(8'd5, ack); send_byte(8'hA5, ack); bus_stop();
        chk("R7 reg5 write no commit", freq_word, {pat(8), pat(7), pat(6), pat(5)});
        bus_start(); send_byte(8'h54, ack); send_byte(8'd8, ack); send_byte(8'h3C, ack); bus_stop();
        chk("R7 reg8 write commit", freq_word, {8'h3C, pat(7), pat(6), 8'hA5});

        // R6: write at out-of-range pointer changes nothing
        snap = regs_flat;
        bus_start(); send_byte(8'h54, ack); send_byte(8'd30, ack); send_byte(8'h99, ack); bus_stop();
        n_cmp++;
        if (regs_flat !== snap) begin
            n_bad++;
            $display("FAIL R6 oor write changed regs actual=%h expected=%h", regs_flat, snap);
        end

        // R8: repeated start in the middle of a write restarts the address phase
        bus_start(); send_byte(8'h54, ack); send_byte(8'd2, ack);
        bus_start(); send_byte(8'h54, ack); send_byte(8'd3, ack); send_byte(8'h77, ack); bus_stop();
        chk("R8 restart write reg3", 32'(regs_flat[3*8 +: 8]), 32'h77);
        chk("R8 restart reg2 untouched", 32'(regs_flat[2*8 +: 8]), 32'(pat(2)));

        finished = 1;
        summary();
        $finish;
    end

endmodule